// File: doc/BRIEF.md
# GPIO Output Change Notifier

This block holds the output side of a 16-pin general-purpose port. Software programs it through a byte-wide register port. Two 24-bit registers are each split into three byte lanes: a data register and an output-enable register. A pin's effective level is its data bit ANDed with its enable bit, and only the low 16 bits count.

The block does not drive pins as static levels. It reports every change of the effective level as an event. After any write that hits one of the six lanes, it compares the new effective level with the level it latched before. In the next cycle it pulses a one-cycle strobe on each pin that changed, together with the new level vector. Because the enable bits take part in the level, a write to the enable register alone can produce events. Reads return the stored register bytes, not the effective level.

Top module: `gpio_evt_notifier`

## Requirements
- R1: After reset the strobe vector, the level vector and all six readable lanes are zero.
- R2: A write to data lane k (address 0x78 + k, k = 0..2) replaces bits [8k+7:8k] of the data register and leaves its other bits unchanged.
- R3: A write to enable lane k (address 0x7c + k, k = 0..2) replaces bits [8k+7:8k] of the enable register and leaves its other bits unchanged.
- R4: `lvl_o` always equals the low 16 bits of data AND enable, as stored after the most recent write.
- R5: In the cycle after a lane write, `chg_o` has a 1 exactly on each pin whose effective level differs from the level before the write. In every other cycle `chg_o` is zero.
- R6: A write that leaves the effective level unchanged produces an all-zero strobe.
- R7: A write to the enable register alone produces events on every pin whose data bit is 1 and whose enable bit flips.
- R8: Writes to lane 2 of either register (bits 23:16) are stored and read back, but never produce an event.
- R9: A write to an address outside the six lanes changes no register, no read value and no output.
- R10: A read of a lane returns the stored register byte, even where the enable or data bit masks the effective level. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the byte port |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Combinational read byte for `addr_i` |
| chg_o | output | 16 | One-cycle per-pin change strobes |
| lvl_o | output | 16 | Latched effective pin levels |

## Verification
The assertions assume that `we_i` is low while reset is asserted and that one byte write occurs per cycle. Under that assumption, each strobe traces back to a write in the previous cycle, and each strobe bit matches a change in `lvl_o`. The stimulus drives writes only between falling edges and releases the strobe after one cycle. Writes go to all six lanes and to unmapped addresses, with random data, back-to-back sequences and repeated writes of the same value.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned LANES     = 3;
  localparam int unsigned PINS      = 16;
  localparam int unsigned REG_W     = LANES * LANE_W;
  localparam logic [ADDR_W-1:0] DATA_BASE = 8'h78;
  localparam logic [ADDR_W-1:0] EN_BASE   = 8'h7c;
endpackage

// File: rtl/gpio_lane_reg.sv
module gpio_lane_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 3,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int unsigned REG_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [REG_W-1:0]  q_o,
  output logic [REG_W-1:0]  nxt_o,
  output logic              hit_o,
  output logic [LANE_W-1:0] rd_o,
  output logic              rd_hit_o
);
  logic [LANES-1:0] sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sel[k] = (addr_i == BASE + ADDR_W'(k));
    assign nxt_o[k*LANE_W +: LANE_W] = (we_i && sel[k]) ? wdata_i : q_o[k*LANE_W +: LANE_W];
  end

  assign hit_o    = we_i && (|sel);
  assign rd_hit_o = |sel;

  always_comb begin
    rd_o = '0;
    for (int k = 0; k < int'(LANES); k++)
      if (sel[k]) rd_o = q_o[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt_o;
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned PINS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [PINS-1:0] eff_nxt_i,
  output logic [PINS-1:0] chg_o,
  output logic [PINS-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      chg_o <= '0;
      lvl_o <= '0;
    end else if (upd_i) begin
      chg_o <= eff_nxt_i ^ lvl_o;
      lvl_o <= eff_nxt_i;
    end else begin
      chg_o <= '0;
    end
endmodule

// File: rtl/gpio_evt_notifier.sv
module gpio_evt_notifier
  import gpio_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o,
  output logic [PINS-1:0]   chg_o,
  output logic [PINS-1:0]   lvl_o
);
  logic [REG_W-1:0]  data_q, data_nxt, en_q, en_nxt;
  logic              data_hit, en_hit, data_rhit, en_rhit;
  logic [LANE_W-1:0] data_rd, en_rd;
  logic [PINS-1:0]   eff_nxt;

  gpio_lane_reg #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .BASE(DATA_BASE)) u_data (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .q_o(data_q), .nxt_o(data_nxt), .hit_o(data_hit), .rd_o(data_rd), .rd_hit_o(data_rhit)
  );

  gpio_lane_reg #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .BASE(EN_BASE)) u_en (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .q_o(en_q), .nxt_o(en_nxt), .hit_o(en_hit), .rd_o(en_rd), .rd_hit_o(en_rhit)
  );

  // upper lane bits are storage only
  logic unused_hi;
  assign unused_hi = ^{data_nxt[REG_W-1:PINS], en_nxt[REG_W-1:PINS], data_q, en_q};

  assign eff_nxt = data_nxt[PINS-1:0] & en_nxt[PINS-1:0];
  assign rdata_o = data_rhit ? data_rd : (en_rhit ? en_rd : '0);

  gpio_chg_detect #(.PINS(PINS)) u_det (
    .clk_i, .rst_ni, .upd_i(data_hit | en_hit), .eff_nxt_i(eff_nxt),
    .chg_o, .lvl_o
  );
endmodule

// File: rtl/gpio_evt_checker.sv
module gpio_evt_checker
  import gpio_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PINS-1:0]   chg_o,
  input logic [PINS-1:0]   lvl_o,
  input logic [REG_W-1:0]  data_q,
  input logic [REG_W-1:0]  en_q
);
  function automatic logic lane_hit(logic [ADDR_W-1:0] a);
    return (a >= DATA_BASE && a < DATA_BASE + ADDR_W'(LANES)) ||
           (a >= EN_BASE   && a < EN_BASE   + ADDR_W'(LANES));
  endfunction

  assert_level_is_and_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o == (data_q[PINS-1:0] & en_q[PINS-1:0]));

  assert_strobe_matches_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o == (lvl_o ^ $past(lvl_o)));

  assert_strobe_needs_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && lane_hit(addr_i)) |=> chg_o == '0);

  assert_top_lane_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == DATA_BASE + 8'd2 || addr_i == EN_BASE + 8'd2)) |=> chg_o == '0);

  assert_unmapped_no_effect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lane_hit(addr_i)) |=> ($stable(data_q) && $stable(en_q) && $stable(lvl_o)));
endmodule

bind gpio_evt_notifier gpio_evt_checker chk_i (
  .clk_i, .rst_ni, .we_i, .addr_i, .chg_o, .lvl_o, .data_q(data_q), .en_q(en_q)
);

// File: tb/gpio_evt_notifier_tb.sv
module gpio_evt_notifier_tb_top;
  logic clk = 0, rst_ni = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [15:0] chg, lvl;
  logic [23:0] m_data = 0, m_en = 0;
  logic [15:0] m_lvl = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_evt_notifier dut_i (.clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .chg_o(chg), .lvl_o(lvl));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a >= 8'h78 && a <= 8'h7a) return m_data[(a-8'h78)*8 +: 8];
    if (a >= 8'h7c && a <= 8'h7e) return m_en[(a-8'h7c)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic rd(string req, logic [7:0] a);
    @(negedge clk); addr = a; #0.5;
    chk(req, {24'h0, rdata}, {24'h0, exp_rd(a)});
  endtask

  task automatic wr(string req, logic [7:0] a, logic [7:0] d);
    logic [15:0] nl, ec;
    @(negedge clk); we = 1; addr = a; wdata = d;
    if (a >= 8'h78 && a <= 8'h7a) m_data[(a-8'h78)*8 +: 8] = d;
    if (a >= 8'h7c && a <= 8'h7e) m_en[(a-8'h7c)*8 +: 8] = d;
    nl = m_data[15:0] & m_en[15:0];
    ec = (exp_rd(a) == d && (a inside {[8'h78:8'h7a], [8'h7c:8'h7e]})) ? (nl ^ m_lvl) : 16'h0;
    m_lvl = nl;
    @(negedge clk); we = 0;
    chk({req, " strobe R5"}, {16'h0, chg}, {16'h0, ec});
    chk({req, " level R4"}, {16'h0, lvl}, {16'h0, m_lvl});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1 chg", {16'h0, chg}, 0);
    chk("R1 lvl", {16'h0, lvl}, 0);
    rst_ni = 1;
    for (int a = 8'h78; a <= 8'h7e; a++) rd("R1 readback", 8'(a));
    // R2 / R3 lane isolation
    wr("R2", 8'h78, 8'hA5); wr("R2", 8'h79, 8'h3C);
    rd("R2", 8'h78); rd("R2", 8'h79);
    wr("R3", 8'h7d, 8'hF0);
    rd("R3", 8'h7c); rd("R3", 8'h7d);
    wr("R3", 8'h7c, 8'hFF);
    // R6 same value again
    wr("R6", 8'h7c, 8'hFF);
    chk("R6 no event", {16'h0, chg}, 0);
    // R7 enable-only change
    wr("R7", 8'h7c, 8'h00);
    wr("R7", 8'h7c, 8'h0F);
    // R8 top lanes
    wr("R8", 8'h7a, 8'hFF); wr("R8", 8'h7e, 8'hFF);
    rd("R8", 8'h7a); rd("R8", 8'h7e);
    // R9 unmapped
    wr("R9", 8'h7b, 8'hFF); wr("R9", 8'h7f, 8'hFF); wr("R9", 8'h00, 8'h12);
    for (int a = 8'h78; a <= 8'h7e; a++) rd("R9", 8'(a));
    // R10 stored bytes, not effective level
    wr("R10", 8'h7d, 8'h00);
    rd("R10", 8'h79); rd("R10", 8'h77);
    // R5 strobe returns to zero after one cycle
    @(negedge clk); chk("R5 idle", {16'h0, chg}, 0);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom % 8)
        0, 1, 2: a = 8'h78 + 8'($urandom % 3);
        3, 4, 5: a = 8'h7c + 8'($urandom % 3);
        6:       a = 8'($urandom);
        default: a = 8'h79;
      endcase
      wr("R5 rand", a, 8'($urandom));
      if (i % 16 == 0) rd("R10 rand", a);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule